// File: doc/BRIEF.md
# Mode-Controlled Direct-Mapped Program Cache

This block sits between a processor's instruction fetch port and a slower external program memory. It owns a bank of 256-bit frames, each holding one fetch packet. A 3-bit mode input decides what that bank is used for. In mapped mode the bank is on-chip program RAM at the bottom of the address space. In the three cache modes it is a direct-mapped instruction cache, with a tag and a valid bit per frame.

The three cache modes differ in what they do with the bank. Enabled mode looks up the bank and fills it on a miss. Freeze mode looks it up but never writes it. Bypass mode neither looks it up nor writes it, so every fetch goes out to external memory. Contents survive mode changes, except that entering enabled mode straight from mapped mode drops every valid bit.

The fetch side is a simple request/valid exchange with one packet in flight. The external side issues a one-cycle read request for an aligned packet address and accepts one response beat.

Top module: `prog_cache`

## Requirements
- R1: After reset, fetch_ready_o is 1, fetch_valid_o is 0, ext_req_o is 0, and the effective mode is mapped. All valid bits are 0.
- R2: mode_i is decoded as follows: 3'b000 is mapped, 3'b010 is cache enabled, 3'b011 is freeze, 3'b100 is bypass. Every other code is reserved.
- R3: In enabled mode, a miss produces exactly one single-cycle ext_req_o pulse, two cycles after acceptance. ext_addr_o carries the fetch address with its low 5 bits cleared. The response data is presented with fetch_valid_o in the same cycle that ext_rvalid_i is high, and the frame, tag and valid bit are written in that same cycle.
- R4: In enabled or freeze mode, a hit returns the stored packet with fetch_valid_o in the cycle after acceptance, and issues no external request.
- R5: In freeze mode, a miss is fetched externally but leaves every frame, tag and valid bit unchanged, so repeating the same miss goes external again.
- R6: In bypass mode, every fetch goes to external memory. The stored frames, tags and valid bits are not changed, and they are still usable once enabled mode returns.
- R7: In mapped mode, an address below NUM_FRAMES*32 bytes reads frame number addr[5 +: log2(NUM_FRAMES)] in the cycle after acceptance, with no external request. A higher address is fetched externally and is not stored.
- R8: Switching into enabled mode from mapped (or reserved) mode clears all valid bits. Switching among enabled, freeze and bypass keeps them.
- R9: Reserved mode codes behave exactly like mapped mode and do not alter tags or valid bits.
- R10: Two addresses that share a frame index but differ in tag conflict. In enabled mode the later miss replaces the earlier line.
- R11: fetch_ready_o is 0 from acceptance until the cycle after fetch_valid_o. A request is accepted only when fetch_req_i and fetch_ready_o are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 3 | Operating mode code |
| fetch_req_i | input | 1 | Fetch request from the processor |
| fetch_addr_i | input | ADDR_W | Byte address of the fetch packet |
| fetch_ready_o | output | 1 | Block is idle and can accept a request |
| fetch_valid_o | output | 1 | fetch_data_o holds the requested packet |
| fetch_data_o | output | DATA_W | Returned fetch packet |
| ext_req_o | output | 1 | One-cycle external read request |
| ext_addr_o | output | ADDR_W | Packet-aligned external read address |
| ext_rvalid_i | input | 1 | External response is valid |
| ext_rdata_i | input | DATA_W | External response packet |

## Verification
The checks assume three things about the environment. mode_i stays stable while a fetch is in flight. ext_rvalid_i is raised only after an ext_req_o pulse has been seen. A mode change is held for at least one clock before the next request is accepted. Under these conditions a flush and a line fill can never coincide, and the latched mode always matches the mode that was in force when the request was accepted. The bench keeps to all three: it changes the mode only between transactions, answers external requests one cycle after it sees them, and spaces every request by at least one idle edge.

// File: rtl/prog_cache_pkg.sv
package prog_cache_pkg;
  typedef enum logic [1:0] {CLS_MAP, CLS_EN, CLS_FRZ, CLS_BYP} mode_cls_e;
  typedef enum logic [1:0] {ST_IDLE, ST_LOOK, ST_WAIT} fsm_e;

  function automatic mode_cls_e decode_mode(input logic [2:0] m);
    case (m)
      3'b010:  return CLS_EN;
      3'b011:  return CLS_FRZ;
      3'b100:  return CLS_BYP;
      default: return CLS_MAP;  // mapped and all reserved codes
    endcase
  endfunction
endpackage

// File: rtl/pc_mode_ctrl.sv
module pc_mode_ctrl
  import prog_cache_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [2:0] mode_i,
  output mode_cls_e  cls_o,
  output logic       flush_o
);
  logic prev_map_q;

  assign cls_o   = decode_mode(mode_i);
  assign flush_o = (cls_o == CLS_EN) && prev_map_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_map_q <= 1'b1;
    else         prev_map_q <= (cls_o == CLS_MAP);
  end
endmodule

// File: rtl/pc_tag_store.sv
module pc_tag_store #(
  parameter int NUM_FRAMES = 2048,
  parameter int TAG_W      = 16,
  localparam int IDX_W     = $clog2(NUM_FRAMES)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  flush_i,
  input  logic [IDX_W-1:0]      rd_idx_i,
  input  logic                  wr_en_i,
  input  logic [IDX_W-1:0]      wr_idx_i,
  input  logic [TAG_W-1:0]      wr_tag_i,
  output logic [TAG_W-1:0]      rd_tag_o,
  output logic                  rd_valid_o,
  output logic [NUM_FRAMES-1:0] valid_vec_o
);
  logic [TAG_W-1:0]      tag_q [NUM_FRAMES];
  logic [NUM_FRAMES-1:0] valid_q;

  always_ff @(posedge clk_i) begin
    if (wr_en_i) tag_q[wr_idx_i] <= wr_tag_i;
  end

  // flush first, a fill in the same cycle still lands
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
    end else begin
      for (int i = 0; i < NUM_FRAMES; i++) begin
        if (wr_en_i && (wr_idx_i == IDX_W'(i))) valid_q[i] <= 1'b1;
        else if (flush_i)                       valid_q[i] <= 1'b0;
      end
    end
  end

  assign rd_tag_o    = tag_q[rd_idx_i];
  assign rd_valid_o  = valid_q[rd_idx_i];
  assign valid_vec_o = valid_q;
endmodule

// File: rtl/pc_data_store.sv
module pc_data_store #(
  parameter int NUM_FRAMES = 2048,
  parameter int DATA_W     = 256,
  localparam int IDX_W     = $clog2(NUM_FRAMES)
) (
  input  logic              clk_i,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [DATA_W-1:0] rd_data_o
);
  logic [DATA_W-1:0] frame_q [NUM_FRAMES];

  always_ff @(posedge clk_i) begin
    if (wr_en_i) frame_q[wr_idx_i] <= wr_data_i;
  end

  assign rd_data_o = frame_q[rd_idx_i];
endmodule

// File: rtl/prog_cache.sv
module prog_cache
  import prog_cache_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 256,
  parameter int NUM_FRAMES = 2048
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [2:0]        mode_i,
  input  logic              fetch_req_i,
  input  logic [ADDR_W-1:0] fetch_addr_i,
  output logic              fetch_ready_o,
  output logic              fetch_valid_o,
  output logic [DATA_W-1:0] fetch_data_o,
  output logic              ext_req_o,
  output logic [ADDR_W-1:0] ext_addr_o,
  input  logic              ext_rvalid_i,
  input  logic [DATA_W-1:0] ext_rdata_i
);
  localparam int OFF_W = 5;
  localparam int IDX_W = $clog2(NUM_FRAMES);
  localparam int TAG_W = ADDR_W - OFF_W - IDX_W;
  localparam int PKT_W = ADDR_W - OFF_W;

  fsm_e              state_q;
  mode_cls_e         cls_now, cls_q;
  logic              flush;
  logic [PKT_W-1:0]  pkt_q;
  logic              ext_req_q;
  logic [IDX_W-1:0]  idx;
  logic [TAG_W-1:0]  tag, rd_tag;
  logic              rd_valid, hit, internal, serve_int, fill_we;
  logic [DATA_W-1:0] rd_data;
  logic [NUM_FRAMES-1:0] valid_vec;
  logic              unused_off;

  assign unused_off = ^fetch_addr_i[OFF_W-1:0];

  pc_mode_ctrl u_mode (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .mode_i (mode_i),
    .cls_o  (cls_now),
    .flush_o(flush)
  );

  assign idx      = pkt_q[IDX_W-1:0];
  assign tag      = pkt_q[PKT_W-1:IDX_W];
  assign internal = (tag == '0);
  assign hit      = rd_valid && (rd_tag == tag);

  always_comb begin
    unique case (cls_q)
      CLS_MAP:         serve_int = internal;
      CLS_EN, CLS_FRZ: serve_int = hit;
      default:         serve_int = 1'b0;
    endcase
  end

  assign fill_we = (state_q == ST_WAIT) && ext_rvalid_i && (cls_q == CLS_EN);

  pc_tag_store #(.NUM_FRAMES(NUM_FRAMES), .TAG_W(TAG_W)) u_tags (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .flush_i    (flush),
    .rd_idx_i   (idx),
    .wr_en_i    (fill_we),
    .wr_idx_i   (idx),
    .wr_tag_i   (tag),
    .rd_tag_o   (rd_tag),
    .rd_valid_o (rd_valid),
    .valid_vec_o(valid_vec)
  );

  pc_data_store #(.NUM_FRAMES(NUM_FRAMES), .DATA_W(DATA_W)) u_data (
    .clk_i    (clk_i),
    .wr_en_i  (fill_we),
    .wr_idx_i (idx),
    .wr_data_i(ext_rdata_i),
    .rd_idx_i (idx),
    .rd_data_o(rd_data)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      cls_q     <= CLS_MAP;
      pkt_q     <= '0;
      ext_req_q <= 1'b0;
    end else begin
      ext_req_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (fetch_req_i) begin
          pkt_q   <= fetch_addr_i[ADDR_W-1:OFF_W];
          cls_q   <= cls_now;
          state_q <= ST_LOOK;
        end
        ST_LOOK: if (serve_int) begin
          state_q <= ST_IDLE;
        end else begin
          ext_req_q <= 1'b1;
          state_q   <= ST_WAIT;
        end
        ST_WAIT: if (ext_rvalid_i) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign fetch_ready_o = (state_q == ST_IDLE);
  assign fetch_valid_o = ((state_q == ST_LOOK) && serve_int) ||
                         ((state_q == ST_WAIT) && ext_rvalid_i);
  assign fetch_data_o  = (state_q == ST_WAIT) ? ext_rdata_i : rd_data;
  assign ext_req_o     = ext_req_q;
  assign ext_addr_o    = {pkt_q, {OFF_W{1'b0}}};
endmodule

// File: rtl/prog_cache_chk.sv
module prog_cache_chk
  import prog_cache_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int NUM_FRAMES = 2048,
  localparam int OFF_W     = 5,
  localparam int IDX_W     = $clog2(NUM_FRAMES),
  localparam int PKT_W     = ADDR_W - OFF_W
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  fetch_ready_o,
  input logic                  fetch_valid_o,
  input logic                  ext_req_o,
  input logic                  ext_rvalid_i,
  input mode_cls_e             cls_q,
  input logic [PKT_W-1:0]      pkt_q,
  input logic                  fill_we,
  input logic                  flush,
  input logic [NUM_FRAMES-1:0] valid_vec
);
  p_busy_on_valid_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_valid_o |-> !fetch_ready_o);

  p_ext_pulse_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_req_o |=> !ext_req_o);

  p_valid_single_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_valid_o |=> !fetch_valid_o);

  p_freeze_no_write_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cls_q == CLS_FRZ) |-> !fill_we);

  p_bypass_ext_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fetch_valid_o && cls_q == CLS_BYP) |-> ext_rvalid_i);

  p_mapped_internal_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ext_req_o && cls_q == CLS_MAP) |-> (pkt_q[PKT_W-1:IDX_W] != '0));

  p_mapped_no_fill_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cls_q == CLS_MAP) |-> !fill_we);

  p_flush_clears_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(flush) && !$past(fill_we)) |-> (valid_vec == '0));
endmodule

bind prog_cache prog_cache_chk #(.ADDR_W(ADDR_W), .NUM_FRAMES(NUM_FRAMES)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .fetch_ready_o(fetch_ready_o),
  .fetch_valid_o(fetch_valid_o),
  .ext_req_o    (ext_req_o),
  .ext_rvalid_i (ext_rvalid_i),
  .cls_q        (cls_q),
  .pkt_q        (pkt_q),
  .fill_we      (fill_we),
  .flush        (flush),
  .valid_vec    (valid_vec)
);

// File: tb/prog_cache_bench.sv
module prog_cache_bench;
  localparam int AW = 16;
  localparam int DW = 256;
  localparam int NF = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [2:0]    mode = 3'b000;
  logic          req = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          ready, fvalid, ereq, ervalid = 1'b0;
  logic [DW-1:0] fdata, erdata = '0;
  logic [AW-1:0] eaddr;

  int checks = 0;
  int errors = 0;
  int cyc_cnt = 0;
  logic [15:0] salt = 16'h0;

  // bench model: 0 map, 1 enabled, 2 freeze, 3 bypass
  bit            m_val [NF];
  logic [AW-1:0] m_tag [NF];
  logic [DW-1:0] m_dat [NF];
  bit            prev_map = 1'b1;
  int            cur_cls = 0;

  always #10 clk = ~clk;

  prog_cache #(.ADDR_W(AW), .DATA_W(DW), .NUM_FRAMES(NF)) u_prog_cache (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode),
    .fetch_req_i(req), .fetch_addr_i(addr),
    .fetch_ready_o(ready), .fetch_valid_o(fvalid), .fetch_data_o(fdata),
    .ext_req_o(ereq), .ext_addr_o(eaddr),
    .ext_rvalid_i(ervalid), .ext_rdata_i(erdata)
  );

  function automatic logic [DW-1:0] ext_pkt(input logic [AW-1:0] pa);
    return {8{salt, pa}};
  endfunction

  function automatic int cls_of(input logic [2:0] m);
    case (m)
      3'b010:  return 1;
      3'b011:  return 2;
      3'b100:  return 3;
      default: return 0;
    endcase
  endfunction

  task automatic chk(input string rq, input string what, input logic [DW-1:0] act,
                     input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic set_mode(input logic [2:0] m);
    @(negedge clk);
    mode = m;
    cur_cls = cls_of(m);
    if (cur_cls == 1 && prev_map) for (int i = 0; i < NF; i++) m_val[i] = 1'b0;
    prev_map = (cur_cls == 0);
  endtask

  task automatic fetch(input logic [AW-1:0] a, input string rq);
    int idx, n_ext, lat, busy_bad;
    logic [AW-1:0] tg, pa, seen_a;
    bit exp_ext, got, pend;
    logic [DW-1:0] exp_d, got_d;
    idx = int'((a >> 5) % NF);
    tg  = a >> 8;
    pa  = a & ~16'd31;
    case (cur_cls)
      0:       exp_ext = (tg != 0);
      1, 2:    exp_ext = !(m_val[idx] && m_tag[idx] == tg);
      default: exp_ext = 1'b1;
    endcase
    exp_d = exp_ext ? ext_pkt(pa) : m_dat[idx];
    @(negedge clk);
    req = 1'b1; addr = a;
    @(posedge clk);
    @(negedge clk);
    req = 1'b0;
    n_ext = 0; lat = -1; got = 0; pend = 0; busy_bad = 0; got_d = '0; seen_a = '0;
    for (int i = 0; i < 20 && !got; i++) begin
      if (pend) begin ervalid = 1'b1; erdata = ext_pkt(seen_a); pend = 0; end
      #1;
      if (ready) busy_bad++;
      if (fvalid) begin got = 1; got_d = fdata; lat = i; end
      else if (ereq) begin n_ext++; seen_a = eaddr; pend = 1; end
      @(negedge clk);
      ervalid = 1'b0;
    end
    chk(rq, "data", got_d, exp_d);
    chk(rq, "ext_count", DW'(n_ext), DW'(exp_ext ? 1 : 0));
    chk(rq, "latency", DW'(lat), DW'(exp_ext ? 2 : 0));
    chk("R11", "busy_while_pending", DW'(busy_bad), '0);
    chk("R11", "ready_after", DW'(ready), DW'(1));
    if (exp_ext) chk("R3", "ext_addr_aligned", DW'(seen_a), DW'(pa));
    if (cur_cls == 1 && exp_ext) begin
      m_val[idx] = 1'b1; m_tag[idx] = tg; m_dat[idx] = ext_pkt(pa);
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc_cnt++;
      if (cyc_cnt > 100000) begin
        errors++; checks++;
        $display("FAIL watchdog actual=%0d expected<100000", cyc_cnt);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    for (int i = 0; i < NF; i++) begin m_val[i] = 0; m_tag[i] = '0; m_dat[i] = '0; end
    repeat (3) @(negedge clk);
    chk("R1", "ready_in_reset", DW'(ready), DW'(1));
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "ready", DW'(ready), DW'(1));
    chk("R1", "valid", DW'(fvalid), '0);
    chk("R1", "ext_req", DW'(ereq), '0);
    fetch(16'h0040, "R1");   // default mapped: internal, no ext request
    fetch(16'h0540, "R1");

    // R2 R3: enabled, fill all frames (offset bits vary)
    set_mode(3'b010);
    for (int i = 0; i < NF; i++) fetch(AW'(16'h1000 + i * 32 + i), "R3");
    salt = 16'h1111;
    // R4: all hit with old contents
    for (int i = 0; i < NF; i++) fetch(AW'(16'h1000 + i * 32 + 31 - i), "R4");
    // R10: conflicts on frames 0..3
    for (int i = 0; i < 4; i++) fetch(AW'(16'h2000 + i * 32), "R10");
    for (int i = 0; i < 4; i++) fetch(AW'(16'h1000 + i * 32), "R10");
    for (int i = 0; i < 4; i++) fetch(AW'(16'h1000 + i * 32), "R10");

    // R5: freeze
    salt = 16'h2222;
    set_mode(3'b011);
    for (int i = 0; i < NF; i++) fetch(AW'(16'h1000 + i * 32), "R5");
    for (int i = 0; i < NF; i++) fetch(AW'(16'h3000 + i * 32), "R5");
    salt = 16'h3333;
    for (int i = 0; i < NF; i++) fetch(AW'(16'h3000 + i * 32), "R5");

    // R6: bypass, then R8 back to enabled keeps valids
    set_mode(3'b100);
    for (int i = 0; i < NF; i++) fetch(AW'(16'h1000 + i * 32), "R6");
    set_mode(3'b010);
    for (int i = 0; i < NF; i++) fetch(AW'(16'h1000 + i * 32), "R8");
    set_mode(3'b011);
    fetch(16'h1020, "R8");

    // R7: mapped mode direct frame reads, high addresses external
    salt = 16'h4444;
    set_mode(3'b000);
    for (int i = 0; i < NF; i++) fetch(AW'(i * 32 + 3), "R7");
    fetch(16'h0100, "R7");
    fetch(16'h1000, "R7");

    // R9: reserved codes act mapped, tags survive into freeze
    set_mode(3'b010);
    for (int i = 0; i < NF; i++) fetch(AW'(16'h5000 + i * 32), "R9");
    begin
      logic [2:0] rsv [4] = '{3'b001, 3'b101, 3'b110, 3'b111};
      for (int k = 0; k < 4; k++) begin
        set_mode(rsv[k]);
        fetch(AW'(k * 32), "R9");
        fetch(AW'(16'h5000 + k * 32), "R9");
        chk("R2", "reserved_is_mapped", DW'(cur_cls), '0);
      end
    end
    set_mode(3'b011);
    for (int i = 0; i < NF; i++) fetch(AW'(16'h5000 + i * 32), "R9");

    // R8: mapped into enabled clears valids
    set_mode(3'b000);
    set_mode(3'b010);
    salt = 16'h5555;
    for (int i = 0; i < NF; i++) fetch(AW'(16'h5000 + i * 32), "R8");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule